// File: doc/BRIEF.md
# Serial Receive FIFO with Fill Trigger and Character Timeout

This block is the receive queue of a serial port. A deserializer upstream hands it one byte at a time. The bytes go into a 16-entry circular buffer, and the CPU reads them out in arrival order through a pop port. The block tells the upstream side exactly how many entries are still free, and it tells it zero while reception is disabled. An upstream that obeys this count never loses a byte.

The CPU is alerted in two ways:

- **Data-full flag.** A sticky flag rises when an accepted byte brings the fill level up to a programmable trigger level. The CPU clears the flag by writing it to zero, and the clear only takes effect once the level has dropped below the trigger.
- **Character timeout.** A small amount of data may never reach the trigger. To cover that case, every byte accepted below the trigger restarts a timer of 15 elementary time units, counted on a single-cycle tick input. If the timer runs out while data is still queued, a timeout flag rises.

Reaching the trigger cancels the timer. The interrupt output is the OR of the two flags, gated by the receive-interrupt-enable bit of the control input.

Top module: `rx_trigger_fifo`

## Requirements
- R1: `free_slots` equals 16 minus `fill_count` while control bit 4 (receive enable) is 1, and equals 0 while that bit is 0.
- R2: A byte offered on `in_valid` while control bit 4 is 0 is not stored, so `fill_count` does not rise.
- R3: Bytes are popped in the order they were accepted, and this holds across wraparound of the 16-entry buffer. `pop_data` shows the oldest stored byte whenever `fill_count` is nonzero.
- R4: An accepted byte and a pop in the same cycle leave `fill_count` unchanged. An accept alone adds one, and a pop alone subtracts one.
- R5: When an accepted byte makes the new `fill_count` equal to or greater than `trig_level`, `data_full` is 1 from the next cycle.
- R6: A pulse on `clr_full` clears `data_full` only if `fill_count` is below `trig_level` in that cycle. Otherwise the flag stays at 1.
- R7: After a byte is accepted with the new level below `trig_level`, the 15th following `etu_tick` sets `timeout_flag`, provided no further byte has been accepted and data is still queued.
- R8: A byte accepted with the new level at or above `trig_level` cancels any running timeout, so `timeout_flag` stays 0 until a later restart expires.
- R9: `rx_irq` is 1 exactly when control bit 6 is 1 and either `data_full` or `timeout_flag` is 1.
- R10: A pop while `fill_count` is 0 has no effect. The level stays 0 and later bytes still come out in order.
- R11: `timeout_flag` clears when a byte is accepted or when the buffer drains to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl | input | 8 | Control: bit 4 is receive enable, bit 6 is receive interrupt enable |
| trig_level | input | 5 | Fill level at which `data_full` is raised (1 to 16) |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| in_valid | input | 1 | Byte offered by the deserializer |
| in_data | input | 8 | Offered byte |
| free_slots | output | 5 | Number of entries the upstream may still send |
| pop | input | 1 | CPU removes the oldest byte |
| pop_data | output | 8 | Oldest stored byte |
| clr_full | input | 1 | CPU write of zero to the data-full flag |
| fill_count | output | 5 | Number of stored bytes |
| data_full | output | 1 | Fill level reached the trigger |
| timeout_flag | output | 1 | Character timeout expired with data queued |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The bench focuses on the following corner cases:

- **Wraparound.** A read or write pointer that wraps late or early corrupts the byte order after the 16th entry.
- **Full buffer.** A free-slot count that is off by one at full would let upstream overrun the buffer.
- **Push and pop together.** A simultaneous push and pop that counted only one side would drift the level.
- **Clear request while still at or above the trigger.** A design that cleared `data_full` unconditionally would drop the flag here.
- **The 14th versus the 15th tick.** A timer that expired one tick off would raise `timeout_flag` in the wrong cycle.
- **Reaching the trigger.** A design that did not cancel the timer would later report a spurious timeout.
- **Pops on an empty buffer.** A design that honoured them would underflow the level.

// File: rtl/rx_fifo_pkg.sv
// Package: shared constants and the per-cycle transfer record for the
// receive FIFO. Assumes an 8-bit control word with fixed bit positions.
package rx_fifo_pkg;
    localparam int RXEN_BIT  = 4;   // receive enable
    localparam int IRQEN_BIT = 6;   // receive interrupt enable

    // What happens to the queue in one cycle
    typedef struct packed {
        logic accept;   // a byte is written at the head
        logic take;     // a byte is removed at the tail
    } rx_xfer_t;
endpackage

// File: rtl/rx_fifo_store.sv
// Module: circular byte store with head/tail pointers and fill count.
// Assumes the caller gates accept against a full buffer and take against
// an empty one; pointers wrap to zero after entry DEPTH-1.
module rx_fifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  rx_fifo_pkg::rx_xfer_t xfer,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CNT_W-1:0]    count,
    output logic [CNT_W-1:0]    count_next
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  head;
    logic [PTR_W-1:0]  tail;

    // Advance a pointer by one with wraparound at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Next fill level from this cycle's accept/take pair
    always_comb begin
        count_next = count;
        unique case ({xfer.accept, xfer.take})
            2'b10:   count_next = count + 1'b1;
            2'b01:   count_next = count - 1'b1;
            default: count_next = count;
        endcase
    end

    // Store the accepted byte at the head
    always_ff @(posedge clk) begin
        if (xfer.accept) mem[head] <= wr_data;
    end

    // Update pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (xfer.accept) head <= bump(head);
            if (xfer.take)   tail <= bump(tail);
            count <= count_next;
        end
    end

    assign rd_data = mem[tail];
endmodule

// File: rtl/rx_full_flag.sv
// Module: sticky data-full flag. Sets when an accepted byte brings the new
// level to or above the trigger; a CPU clear is honoured only while the
// current level is below the trigger. Set takes priority over clear.
module rx_full_flag #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] count_next,
    input  logic [CNT_W-1:0] trig,
    input  logic             clr_req,
    output logic             full
);
    logic set_now;
    logic clr_now;

    // Decide set and clear for this cycle
    always_comb begin
        set_now = accept && (count_next >= trig);
        clr_now = clr_req && (count < trig);
    end

    // Hold the flag between events
    always_ff @(posedge clk) begin
        if (!rst_n)       full <= 1'b0;
        else if (set_now) full <= 1'b1;
        else if (clr_now) full <= 1'b0;
    end
endmodule

// File: rtl/rx_char_timeout.sv
// Module: character timeout. Restarts on each byte accepted below the
// trigger, is cancelled by a byte that reaches it, and counts TMO_ETU
// ticks. Expiry with data left raises the flag; an accept or an empty
// buffer clears it. Assumes etu_tick is a one-cycle pulse.
module rx_char_timeout #(
    parameter int TMO_ETU = 15,
    localparam int TC_W   = $clog2(TMO_ETU + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic below_trig,
    input  logic tick,
    input  logic data_left,
    output logic tmo_flag
);
    logic            running;
    logic [TC_W-1:0] ticks;
    logic            expire;

    // Expiry happens on the last tick of a running window
    always_comb expire = !accept && running && tick && (ticks == TC_W'(TMO_ETU - 1));

    // Run, restart or cancel the tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            ticks   <= '0;
        end else if (accept) begin
            running <= below_trig;
            ticks   <= '0;
        end else if (running && tick) begin
            if (expire) running <= 1'b0;
            else        ticks   <= ticks + 1'b1;
        end
    end

    // Flag expiry while bytes are still queued
    always_ff @(posedge clk) begin
        if (!rst_n)                    tmo_flag <= 1'b0;
        else if (accept || !data_left) tmo_flag <= 1'b0;
        else if (expire)               tmo_flag <= 1'b1;
    end
endmodule

// File: rtl/rx_trigger_fifo.sv
// Module: top of the serial receive queue. Gates incoming bytes by the
// receive-enable bit and free space, advertises free slots, and combines
// the fill trigger and the character timeout into one interrupt.
// Assumes trig_level lies in 1..DEPTH and ctrl is held by software.
module rx_trigger_fifo #(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 16,
    parameter int TMO_ETU = 15,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        ctrl,
    input  logic [CNT_W-1:0]  trig_level,
    input  logic              etu_tick,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [CNT_W-1:0]  free_slots,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    input  logic              clr_full,
    output logic [CNT_W-1:0]  fill_count,
    output logic              data_full,
    output logic              timeout_flag,
    output logic              rx_irq
);
    import rx_fifo_pkg::*;

    rx_xfer_t         xfer;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             rx_en;

    // Gate transfers by enable, space and content
    always_comb begin
        rx_en       = ctrl[RXEN_BIT];
        xfer.accept = in_valid && rx_en && (cnt != CNT_W'(DEPTH));
        xfer.take   = pop && (cnt != '0);
    end

    rx_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer      (xfer),
        .wr_data   (in_data),
        .rd_data   (pop_data),
        .count     (cnt),
        .count_next(cnt_next)
    );

    rx_full_flag #(.CNT_W(CNT_W)) u_full (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (xfer.accept),
        .count     (cnt),
        .count_next(cnt_next),
        .trig      (trig_level),
        .clr_req   (clr_full),
        .full      (data_full)
    );

    rx_char_timeout #(.TMO_ETU(TMO_ETU)) u_tmo (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (xfer.accept),
        .below_trig(cnt_next < trig_level),
        .tick      (etu_tick),
        .data_left (cnt_next != '0),
        .tmo_flag  (timeout_flag)
    );

    // Advertise space only while reception is enabled
    always_comb free_slots = rx_en ? CNT_W'(DEPTH) - cnt : '0;

    // Interrupt from either source, gated by the enable bit
    always_comb rx_irq = ctrl[IRQEN_BIT] && (data_full || timeout_flag);

    assign fill_count = cnt;
endmodule

// File: rtl/rx_trigger_fifo_chk.sv
// Module: assertion checker for rx_trigger_fifo, bound to every instance.
// Observes ports only.
module rx_trigger_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       ctrl,
    input logic [CNT_W-1:0] trig_level,
    input logic             in_valid,
    input logic             pop,
    input logic             clr_full,
    input logic [CNT_W-1:0] free_slots,
    input logic [CNT_W-1:0] fill_count,
    input logic             data_full,
    input logic             timeout_flag,
    input logic             rx_irq
);
    // R1
    free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(free_slots) + int'(fill_count)) <= DEPTH);

    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[4] && !pop) |=> (fill_count == $past(fill_count)));

    // R4
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[4] && pop && fill_count != '0 && int'(fill_count) != DEPTH)
        |=> $stable(fill_count));

    // R5
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[4] && !pop && int'(fill_count) < DEPTH &&
         (int'(fill_count) + 1) >= int'(trig_level)) |=> data_full);

    // R6
    full_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_full && fill_count >= trig_level) |=> data_full);

    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ctrl[4] && !pop && int'(fill_count) < DEPTH &&
         (int'(fill_count) + 1) >= int'(trig_level)) |=> !timeout_flag);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[6] |-> !rx_irq);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0 && !(in_valid && ctrl[4])) |=> (fill_count == '0));

    // R11
    drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_count == '0) |-> !timeout_flag);
endmodule

bind rx_trigger_fifo rx_trigger_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl        (ctrl),
    .trig_level  (trig_level),
    .in_valid    (in_valid),
    .pop         (pop),
    .clr_full    (clr_full),
    .free_slots  (free_slots),
    .fill_count  (fill_count),
    .data_full   (data_full),
    .timeout_flag(timeout_flag),
    .rx_irq      (rx_irq)
);

// File: tb/rx_trigger_fifo_bench.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a reference model built from the requirements.
module rx_trigger_fifo_bench;
    localparam int DEPTH = 16;
    localparam int TMO   = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctrl = '0;
    logic [4:0] trig_level = 5'd4;
    logic       etu_tick = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic [4:0] free_slots;
    logic       pop = 1'b0;
    logic [7:0] pop_data;
    logic       clr_full = 1'b0;
    logic [4:0] fill_count;
    logic       data_full;
    logic       timeout_flag;
    logic       rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_mem [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0, m_tc = 0;
    bit m_full = 0, m_run = 0, m_tflag = 0;

    always #2 clk = ~clk;

    rx_trigger_fifo u_rx_trigger_fifo (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .trig_level(trig_level),
        .etu_tick(etu_tick), .in_valid(in_valid), .in_data(in_data),
        .free_slots(free_slots), .pop(pop), .pop_data(pop_data),
        .clr_full(clr_full), .fill_count(fill_count), .data_full(data_full),
        .timeout_flag(timeout_flag), .rx_irq(rx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_free();
        return ctrl[4] ? DEPTH - m_cnt : 0;
    endfunction

    function automatic int exp_irq();
        return (ctrl[6] && (m_full || m_tflag)) ? 1 : 0;
    endfunction

    // advance the model by one clock edge using the current inputs
    task automatic model_step();
        bit acc, tk, exp_now;
        int nc;
        acc = in_valid && ctrl[4] && (m_cnt < DEPTH);
        tk  = pop && (m_cnt > 0);
        nc  = m_cnt + int'(acc) - int'(tk);
        exp_now = 0;
        if (acc) begin
            m_mem[m_head] = in_data;
            m_head = (m_head + 1) % DEPTH;
        end
        if (tk) m_tail = (m_tail + 1) % DEPTH;
        if (acc && nc >= int'(trig_level)) m_full = 1;
        else if (clr_full && m_cnt < int'(trig_level)) m_full = 0;
        if (acc) begin
            m_run = (nc < int'(trig_level));
            m_tc = 0;
        end else if (m_run && etu_tick) begin
            if (m_tc == TMO - 1) begin
                m_run = 0;
                exp_now = 1;
            end else m_tc++;
        end
        if (acc || nc == 0) m_tflag = 0;
        else if (exp_now) m_tflag = 1;
        m_cnt = nc;
    endtask

    // one cycle: inputs set at negedge, compare combinational, clock, compare state
    task automatic cycle();
        #1;
        chk("R1 free_slots", int'(free_slots), exp_free());
        if (m_cnt > 0) chk("R3 pop_data", int'(pop_data), int'(m_mem[m_tail]));
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R4 fill_count", int'(fill_count), m_cnt);
        chk("R5 data_full", int'(data_full), int'(m_full));
        chk("R7 timeout_flag", int'(timeout_flag), int'(m_tflag));
        chk("R9 rx_irq", int'(rx_irq), exp_irq());
    endtask

    task automatic idle_inputs();
        in_valid = 0; pop = 0; clr_full = 0; etu_tick = 0;
    endtask

    task automatic push(input logic [7:0] b);
        idle_inputs(); in_valid = 1; in_data = b; cycle(); idle_inputs();
    endtask

    task automatic take();
        idle_inputs(); pop = 1; cycle(); idle_inputs();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R4 reset fill_count", int'(fill_count), 0);
        chk("R5 reset data_full", int'(data_full), 0);
        chk("R7 reset timeout_flag", int'(timeout_flag), 0);
        chk("R1 reset free_slots disabled", int'(free_slots), 0);

        // R2: bytes ignored while receive is disabled
        ctrl = 8'h00;
        for (int i = 0; i < 3; i++) push(8'hA0 + 8'(i));
        chk("R2 disabled no store", int'(fill_count), 0);

        // R10: pop on empty
        take();
        chk("R10 empty pop", int'(fill_count), 0);

        // R7: timeout after exactly 15 ticks below trigger
        ctrl = 8'h50; trig_level = 5'd4;
        push(8'h11); push(8'h22); push(8'h33);
        for (int i = 0; i < TMO - 1; i++) begin
            idle_inputs(); etu_tick = 1; cycle();
        end
        idle_inputs();
        chk("R7 no timeout after 14 ticks", int'(timeout_flag), 0);
        etu_tick = 1; cycle(); idle_inputs();
        chk("R7 timeout at 15th tick", int'(timeout_flag), 1);
        chk("R9 irq from timeout", int'(rx_irq), 1);

        // R11/R5/R8: reaching trigger clears timeout, sets full, cancels timer
        push(8'h44);
        chk("R11 accept clears timeout", int'(timeout_flag), 0);
        chk("R5 full at trigger", int'(data_full), 1);
        for (int i = 0; i < 20; i++) begin
            idle_inputs(); etu_tick = 1; cycle();
        end
        idle_inputs();
        chk("R8 cancelled timer silent", int'(timeout_flag), 0);

        // R6: clear ignored at trigger, honoured below
        clr_full = 1; cycle(); idle_inputs();
        chk("R6 clear ignored at trigger", int'(data_full), 1);
        take();
        clr_full = 1; cycle(); idle_inputs();
        chk("R6 clear below trigger", int'(data_full), 0);
        ctrl = 8'h10;
        chk("R9 irq gated off", int'(rx_irq), 0);

        // R4: simultaneous push and pop
        idle_inputs(); in_valid = 1; in_data = 8'h55; pop = 1; cycle(); idle_inputs();
        chk("R4 push+pop same count", int'(fill_count), 3);

        // R3/R1: fill to full across wrap, then drain in order
        trig_level = 5'd16;
        while (m_cnt < DEPTH) push(8'(8'h80 + m_cnt));
        chk("R1 free zero when full", int'(free_slots), 0);
        while (m_cnt > 0) take();
        take();
        chk("R10 empty pop after drain", int'(fill_count), 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            idle_inputs();
            if (n % 250 == 0) trig_level = 5'(1 + ($urandom % DEPTH));
            ctrl = 8'h00;
            ctrl[4] = ($urandom % 10) != 0;
            ctrl[6] = $urandom % 2;
            in_valid = (exp_free() > 0) && (($urandom % 3) != 0);
            in_data  = 8'($urandom);
            pop      = ($urandom % ((n / 500) % 2 == 0 ? 3 : 6)) == 0;
            clr_full = ($urandom % 8) == 0;
            etu_tick = ($urandom % 2) == 0;
            cycle();
        end
        idle_inputs();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule